// File: doc/BRIEF.md
# Indirect-Access Event Counter Monitor

This block watches a processor core and counts what it does. It holds a bank of event counters and one latency counter. Each event counter is tied to one of the core's single-cycle event strobes through a programmable event number. The latency counter adds one for every cycle in which the core's busy line is high. All counting is gated by one run flag. Counters saturate at all-ones and do not wrap.

Software reaches the block through an AXI4-Lite slave that decodes only two words. A write to the control word latches a function code. The data-word accesses that follow are then interpreted by that function: a command bitmask, an event assignment, or a counter readout. A command takes a snapshot of every live counter into a shadow copy in one cycle. Readout walks through the shadow copies with a pointer that advances on its own, so the counters keep running while software reads them.

Top module: `evmon_top`

## Requirements
- R1: After reset, BVALID and RVALID are low, all counters and shadows hold zero, counting is stopped, every event counter is disabled (event number 0x3F), the pointer is 0 and no function is selected (the control word reads 0).
- R2: AWREADY and WREADY rise together, in the same cycle, when AWVALID and WVALID are both high and no write response is pending. BVALID rises on the next cycle with BRESP = 0 and stays high until BREADY is seen. No write is accepted while BVALID is high.
- R3: ARREADY is high whenever no read response is pending. RVALID rises the cycle after acceptance with RRESP = 0, and RDATA stays stable until RREADY is seen.
- R4: A write to byte offset 0x10 latches the 32-bit function code. It stays in force until the next such write and reads back unchanged from 0x10.
- R5: With code 0x0004A404 in force, a data write (offset 0x14) is a command mask: bit0 returns the pointer to entry 0, bit1 copies every live counter to its shadow, bit2 stops counting, bit3 starts counting, and bit4 clears every live counter.
- R6: Within one command, clear blocks start, stop beats start, and a sample taken together with a clear captures the values from before the clear.
- R7: With code 0x0004A207 in force, each data write puts bits [5:0] into the event number of the event counter at the pointer, then advances the pointer. A write at the latency entry (index 5) changes nothing but still advances the pointer. The pointer wraps from 5 back to 0.
- R8: While running, an event counter whose event number n is below the number of strobe inputs adds one on each cycle in which strobe bit n is high. Bit 0 is the valid-instruction strobe. An event number of 0x3F, or any other number at or above the input count, never counts.
- R9: While running, the latency counter adds one on each cycle in which busy is high.
- R10: With code 0x0004AC1F in force, each data read returns the shadow value at the pointer, zero-extended, and then advances the pointer. Entries 0 to 4 are the event counters and entry 5 is the latency counter; after entry 5 the pointer goes back to 0.
- R11: Shadow values change only on a sample command, so further counting does not alter what readout returns.
- R12: A live counter at all-ones keeps that value on further increments.
- R13: A data access while no known function code is in force, and any access at an offset other than 0x10 or 0x14, completes with OKAY. The write is ignored (no pointer, counter or configuration change) and the read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data (full-word writes) |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| evt_strobe_i | input | NUM_SRC | One-cycle event strobes from the core; bit 0 is instruction executed |
| busy_i | input | 1 | Core busy level for the latency counter |

## Verification
A write acts on the clock edge that accepts it. AWREADY and WREADY are combinational, so the bench checks them between driving the valids and that edge, and checks BVALID half a cycle after the edge. A read is captured on the accepting edge, and RVALID with its data is checked at the following falling edge. A command's effect on the counters and shadows shows from the next edge on, so strobes are driven only from the falling edge after the command's response. The bench keeps a cycle-level model of run state, pointer, event numbers, live counts and shadows, built from the requirements. Every readout is compared with that model, using an 8-bit counter width so that saturation can be reached.

// File: rtl/evmon_pkg.sv
package evmon_pkg;

   localparam logic [31:0] FN_CODE_CMD   = 32'h0004_A404;
   localparam logic [31:0] FN_CODE_EVCFG = 32'h0004_A207;
   localparam logic [31:0] FN_CODE_READ  = 32'h0004_AC1F;

   localparam int EVT_W   = 6;
   localparam logic [EVT_W-1:0] EVT_DISABLED = 6'h3F;

   typedef enum logic [1:0] {
      FN_NONE,
      FN_COMMAND,
      FN_EVCFG,
      FN_READOUT
   } fn_e;

   // bit order of the command mask is fixed by software
   typedef struct packed {
      logic clear;    // bit4
      logic start;    // bit3
      logic stop;     // bit2
      logic sample;   // bit1
      logic ptr_rst;  // bit0
   } cmd_t;

   function automatic fn_e decode_fn(input logic [31:0] code);
      case (code)
         FN_CODE_CMD:   return FN_COMMAND;
         FN_CODE_EVCFG: return FN_EVCFG;
         FN_CODE_READ:  return FN_READOUT;
         default:       return FN_NONE;
      endcase
   endfunction

   function automatic cmd_t unpack_cmd(input logic [4:0] bits);
      cmd_t c;
      c = cmd_t'(bits);
      return c;
   endfunction

endpackage

// File: rtl/evmon_axil.sv
module evmon_axil #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic              s_wvalid,
   output logic              s_wready,
   input  logic [DATA_W-1:0] s_wdata,
   output logic              s_bvalid,
   input  logic              s_bready,
   output logic [1:0]        s_bresp,
   input  logic              s_arvalid,
   output logic              s_arready,
   input  logic [ADDR_W-1:0] s_araddr,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic [DATA_W-1:0] s_rdata,
   output logic [1:0]        s_rresp,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_word
);

   logic bvalid_q, rvalid_q;
   logic [DATA_W-1:0] rdata_q;

   // both channels taken in one beat, one write in flight at most
   assign wr_en     = s_awvalid & s_wvalid & ~bvalid_q;
   assign s_awready = wr_en;
   assign s_wready  = wr_en;
   assign wr_addr   = s_awaddr;
   assign wr_data   = s_wdata;

   assign s_arready = ~rvalid_q;
   assign rd_en     = s_arvalid & ~rvalid_q;
   assign rd_addr   = s_araddr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bvalid_q <= 1'b0;
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else begin
         if (wr_en)         bvalid_q <= 1'b1;
         else if (s_bready) bvalid_q <= 1'b0;
         if (rd_en) begin
            rvalid_q <= 1'b1;
            rdata_q  <= rd_word;
         end else if (s_rready) begin
            rvalid_q <= 1'b0;
         end
      end
   end

   assign s_bvalid = bvalid_q;
   assign s_rvalid = rvalid_q;
   assign s_rdata  = rdata_q;
   assign s_bresp  = 2'b00;
   assign s_rresp  = 2'b00;

   p_resp_follows_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (s_awvalid && s_wvalid && s_awready) |=> s_bvalid);
   p_bvalid_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (s_bvalid && !s_bready) |=> s_bvalid);
   p_rdata_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));
   p_read_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (s_arvalid && s_arready) |=> s_rvalid);

endmodule

// File: rtl/evmon_ctr.sv
module evmon_ctr #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic             smp,
   output logic [CNT_W-1:0] live,
   output logic [CNT_W-1:0] shadow
);

   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

   logic [CNT_W-1:0] live_q, shadow_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q   <= '0;
         shadow_q <= '0;
      end else begin
         if (clr)                            live_q <= '0;
         else if (inc && live_q != ALL_ONES) live_q <= live_q + 1'b1;
         if (smp)                            shadow_q <= live_q;
      end
   end

   assign live   = live_q;
   assign shadow = shadow_q;

   p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (live == ALL_ONES && !clr) |=> (live == ALL_ONES));
   p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (live == '0));
   p_sample_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      smp |=> (shadow == $past(live)));
   p_shadow_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !smp |=> $stable(shadow));

endmodule

// File: rtl/evmon_top.sv
module evmon_top
   import evmon_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int NUM_EVT = 5,
   parameter int NUM_SRC = 8,
   parameter int CNT_W   = 32,
   parameter logic [ADDR_W-1:0] CTRL_OFF = 'h10,
   parameter logic [ADDR_W-1:0] DATA_OFF = 'h14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               s_awvalid,
   output logic               s_awready,
   input  logic [ADDR_W-1:0]  s_awaddr,
   input  logic               s_wvalid,
   output logic               s_wready,
   input  logic [31:0]        s_wdata,
   output logic               s_bvalid,
   input  logic               s_bready,
   output logic [1:0]         s_bresp,
   input  logic               s_arvalid,
   output logic               s_arready,
   input  logic [ADDR_W-1:0]  s_araddr,
   output logic               s_rvalid,
   input  logic               s_rready,
   output logic [31:0]        s_rdata,
   output logic [1:0]         s_rresp,
   input  logic [NUM_SRC-1:0] evt_strobe_i,
   input  logic               busy_i
);

   localparam int NUM_ENT = NUM_EVT + 1;          // event counters plus latency
   localparam int PTR_W   = $clog2(NUM_ENT);
   localparam int EXT_W   = 2 ** EVT_W;
   localparam logic [PTR_W-1:0] LAST_ENT = PTR_W'(NUM_ENT - 1);

   generate
      if (NUM_EVT < 1 || CNT_W < 1 || CNT_W > 32 || NUM_SRC < 1 || NUM_SRC >= EXT_W
          || ADDR_W < 5) begin : g_bad_cfg
         $error("evmon_top: parameter set out of range");
      end
   endgenerate

   logic              wr_en, rd_en;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic [31:0]       wr_data, rd_word;

   evmon_axil #(.ADDR_W(ADDR_W), .DATA_W(32)) u_axil (
      .clk, .rst_n,
      .s_awvalid, .s_awready, .s_awaddr, .s_wvalid, .s_wready, .s_wdata,
      .s_bvalid, .s_bready, .s_bresp,
      .s_arvalid, .s_arready, .s_araddr, .s_rvalid, .s_rready, .s_rdata, .s_rresp,
      .wr_en, .wr_addr, .wr_data, .rd_en, .rd_addr, .rd_word
   );

   // function select and decoded data-word actions
   logic [31:0]      fn_code_q;
   fn_e              fn_sel;
   cmd_t             cmd;
   logic             wr_data_hit, cmd_fire, cfg_fire, rdo_fire;
   logic [PTR_W-1:0] ptr_q;
   logic             run_q;
   logic             clr_all, smp_all;

   assign fn_sel      = decode_fn(fn_code_q);
   assign cmd         = unpack_cmd(wr_data[4:0]);
   assign wr_data_hit = wr_en && (wr_addr == DATA_OFF);
   assign cmd_fire    = wr_data_hit && (fn_sel == FN_COMMAND);
   assign cfg_fire    = wr_data_hit && (fn_sel == FN_EVCFG);
   assign rdo_fire    = rd_en && (rd_addr == DATA_OFF) && (fn_sel == FN_READOUT);
   assign clr_all     = cmd_fire && cmd.clear;
   assign smp_all     = cmd_fire && cmd.sample;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fn_code_q <= '0;
         ptr_q     <= '0;
         run_q     <= 1'b0;
      end else begin
         if (wr_en && wr_addr == CTRL_OFF) fn_code_q <= wr_data;
         if (cmd_fire && cmd.ptr_rst)
            ptr_q <= '0;
         else if (cfg_fire || rdo_fire)
            ptr_q <= (ptr_q == LAST_ENT) ? '0 : ptr_q + 1'b1;
         if (cmd_fire && cmd.stop)
            run_q <= 1'b0;
         else if (cmd_fire && cmd.start && !cmd.clear)
            run_q <= 1'b1;
      end
   end

   // event number per event counter
   logic [EVT_W-1:0] evt_sel_q [NUM_EVT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_EVT; i++) evt_sel_q[i] <= EVT_DISABLED;
      end else begin
         for (int i = 0; i < NUM_EVT; i++)
            if (cfg_fire && ptr_q == PTR_W'(i)) evt_sel_q[i] <= wr_data[EVT_W-1:0];
      end
   end

   // disabled and unused event numbers land on constant-zero bits
   logic [EXT_W-1:0] strobe_ext;
   assign strobe_ext = {{(EXT_W - NUM_SRC){1'b0}}, evt_strobe_i};

   logic [CNT_W-1:0] live_v   [NUM_ENT];
   logic [CNT_W-1:0] shadow_v [NUM_ENT];

   generate
      for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
         logic inc;
         if (g < NUM_EVT) begin : g_event
            assign inc = run_q & strobe_ext[evt_sel_q[g]];
         end else begin : g_latency
            assign inc = run_q & busy_i;
         end
         evmon_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk, .rst_n,
            .clr(clr_all), .inc(inc), .smp(smp_all),
            .live(live_v[g]), .shadow(shadow_v[g])
         );
      end
   endgenerate

   // read path
   logic [CNT_W-1:0] slot_val;

   always_comb begin
      slot_val = '0;
      for (int i = 0; i < NUM_ENT; i++)
         if (ptr_q == PTR_W'(i)) slot_val = shadow_v[i];
   end

   always_comb begin
      if (rd_addr == CTRL_OFF)
         rd_word = fn_code_q;
      else if (rd_addr == DATA_OFF && fn_sel == FN_READOUT)
         rd_word = 32'(slot_val);
      else
         rd_word = '0;
   end

   p_ptr_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= LAST_ENT);
   p_stop_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_fire && cmd.stop) |=> !run_q);
   p_clear_blocks_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_fire && cmd.clear && !cmd.stop) |=> (run_q == $past(run_q)));
   p_idle_write_ptr_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data_hit && fn_sel == FN_NONE) |=> $stable(ptr_q));
   p_idle_read_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == DATA_OFF && fn_sel != FN_READOUT) |=> (s_rdata == '0));
   p_stopped_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !clr_all) |=> $stable(live_v[0]));

endmodule

// File: tb/evmon_top_tb.sv
module evmon_top_tb;

   localparam int CLK_PERIOD = 10;
   localparam int SRC  = 4;
   localparam int CW   = 8;
   localparam int NEVT = 5;
   localparam int NENT = NEVT + 1;
   localparam int CMAX = (1 << CW) - 1;
   localparam logic [31:0] C_CMD = 32'h0004_A404;
   localparam logic [31:0] C_CFG = 32'h0004_A207;
   localparam logic [31:0] C_RD  = 32'h0004_AC1F;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0, busy = 0;
   logic [7:0] awaddr = 0, araddr = 0;
   logic [31:0] wdata = 0;
   logic [SRC-1:0] strobe = 0;
   logic awready, wready, bvalid, arready, rvalid;
   logic [1:0] bresp, rresp;
   logic [31:0] rdata;

   always #(CLK_PERIOD / 2) clk = ~clk;

   evmon_top #(.ADDR_W(8), .NUM_EVT(NEVT), .NUM_SRC(SRC), .CNT_W(CW)) u_dut (
      .clk, .rst_n,
      .s_awvalid(awvalid), .s_awready(awready), .s_awaddr(awaddr),
      .s_wvalid(wvalid), .s_wready(wready), .s_wdata(wdata),
      .s_bvalid(bvalid), .s_bready(bready), .s_bresp(bresp),
      .s_arvalid(arvalid), .s_arready(arready), .s_araddr(araddr),
      .s_rvalid(rvalid), .s_rready(rready), .s_rdata(rdata), .s_rresp(rresp),
      .evt_strobe_i(strobe), .busy_i(busy)
   );

   int checks = 0;
   int errors = 0;

   // requirement-level model
   int m_sel [NEVT];
   int m_cnt [NENT];
   int m_shd [NENT];
   int m_ptr = 0;
   bit m_run = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   task automatic axi_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      awvalid = 1; wvalid = 1; awaddr = a; wdata = d;
      #1 chk("R2 awready/wready", {30'd0, awready, wready}, 32'd3);
      @(posedge clk);
      @(negedge clk);
      awvalid = 0; wvalid = 0;
      chk("R2 bvalid/bresp", {29'd0, bvalid, bresp}, 32'd4);
      bready = 1;
      @(posedge clk);
      @(negedge clk);
      bready = 0;
   endtask

   task automatic axi_rd(input logic [7:0] a, input int hold, output logic [31:0] d);
      @(negedge clk);
      arvalid = 1; araddr = a;
      #1 chk("R3 arready", {31'd0, arready}, 32'd1);
      @(posedge clk);
      @(negedge clk);
      arvalid = 0;
      chk("R3 rvalid/rresp", {29'd0, rvalid, rresp}, 32'd4);
      d = rdata;
      for (int h = 0; h < hold; h++) begin
         @(posedge clk);
         @(negedge clk);
         chk("R3 rdata held", {rvalid, rdata[30:0]}, {1'b1, d[30:0]});
      end
      rready = 1;
      @(posedge clk);
      @(negedge clk);
      rready = 0;
   endtask

   task automatic command(input logic [4:0] m);
      axi_wr(8'h10, C_CMD);
      axi_wr(8'h14, {27'd0, m});
      if (m[1]) for (int k = 0; k < NENT; k++) m_shd[k] = m_cnt[k];
      if (m[4]) for (int k = 0; k < NENT; k++) m_cnt[k] = 0;
      if (m[2]) m_run = 0;
      else if (m[3] && !m[4]) m_run = 1;
      if (m[0]) m_ptr = 0;
   endtask

   task automatic cfg(input int ev);
      axi_wr(8'h14, 32'(ev));
      if (m_ptr < NEVT) m_sel[m_ptr] = ev & 63;
      m_ptr = (m_ptr + 1) % NENT;
   endtask

   task automatic tick(input logic [SRC-1:0] pat, input bit bz, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         strobe = pat; busy = bz;
         @(posedge clk);
         if (m_run) begin
            for (int k = 0; k < NEVT; k++)
               if (m_sel[k] < SRC && pat[m_sel[k]] && m_cnt[k] < CMAX) m_cnt[k]++;
            if (bz && m_cnt[NEVT] < CMAX) m_cnt[NEVT]++;
         end
      end
      @(negedge clk);
      strobe = 0; busy = 0;
   endtask

   task automatic read_slots(input string req, input int n);
      logic [31:0] d;
      axi_wr(8'h10, C_RD);
      for (int i = 0; i < n; i++) begin
         axi_rd(8'h14, (i == 1) ? 2 : 0, d);
         chk(req, d, 32'(m_shd[m_ptr]));
         m_ptr = (m_ptr + 1) % NENT;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      for (int k = 0; k < NEVT; k++) m_sel[k] = 63;
      for (int k = 0; k < NENT; k++) begin m_cnt[k] = 0; m_shd[k] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1 bvalid/rvalid", {30'd0, bvalid, rvalid}, 32'd0);
      axi_rd(8'h10, 0, d);
      chk("R1 R4 control word", d, 32'd0);
      axi_rd(8'h14, 0, d);
      chk("R13 data read without function", d, 32'd0);
      command(5'h03);
      read_slots("R1 shadows zero", NENT);

      // R7 configuration with wrap and ignored latency slot
      command(5'h01);
      axi_wr(8'h10, C_CFG);
      cfg(2); cfg(1); cfg(2); cfg(3); cfg(63); cfg(1); cfg(0);

      // R6 clear blocks start
      command(5'h18);
      tick(4'b1111, 1, 5);
      command(5'h03);
      read_slots("R6 clear blocks start", NENT);

      // R5 R8 R9 counting, then stop
      command(5'h08);
      tick(4'b0001, 0, 3);
      tick(4'b0110, 0, 4);
      tick(4'b1111, 0, 2);
      tick(4'b0000, 1, 7);
      command(5'h04);
      tick(4'b1111, 1, 5);
      command(5'h03);
      read_slots("R5 R8 R9 R10 counts and wrap", NENT + 1);
      chk("R8 counter0 counts strobe0", 32'(m_shd[0]), 32'd5);
      chk("R9 latency cycles", 32'(m_shd[NEVT]), 32'd7);

      // R11 shadow untouched by counting
      command(5'h08);
      tick(4'b0001, 0, 4);
      command(5'h01);
      read_slots("R11 shadow held", 1);
      command(5'h03);
      read_slots("R11 after new sample", 1);

      // R6 sample together with clear keeps old values
      command(5'h13);
      read_slots("R6 sample before clear", NENT);

      // R6 stop beats start
      command(5'h0C);
      tick(4'b1111, 1, 3);
      command(5'h03);
      read_slots("R6 stop beats start", NENT);

      // R12 saturation
      command(5'h08);
      tick(4'b0001, 1, 300);
      command(5'h03);
      read_slots("R12 saturation", NENT);
      chk("R12 counter0 all-ones", 32'(m_shd[0]), 32'(CMAX));

      // R13 unknown code: writes ignored, reads zero
      command(5'h01);
      axi_wr(8'h10, 32'h0001_2345);
      axi_wr(8'h14, 32'h0000_001F);
      axi_rd(8'h10, 0, d);
      chk("R4 code read back", d, 32'h0001_2345);
      axi_rd(8'h14, 0, d);
      chk("R13 unknown code read", d, 32'd0);
      axi_wr(8'h04, 32'h0000_001F);
      axi_rd(8'h04, 0, d);
      chk("R13 unmapped offset read", d, 32'd0);
      read_slots("R13 state unchanged", 1);

      // R8 event number beyond strobe inputs never counts
      command(5'h01);
      axi_wr(8'h10, C_CFG);
      cfg(5);
      command(5'h10);
      tick(4'b1111, 0, 3);
      command(5'h03);
      read_slots("R8 out-of-range event", 2);

      // R2 response backpressure
      @(negedge clk);
      awvalid = 1; wvalid = 1; awaddr = 8'h10; wdata = C_RD;
      @(posedge clk);
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
         #1 chk("R2 bvalid held, no accept", {30'd0, bvalid, awready}, 32'd2);
         @(posedge clk);
         @(negedge clk);
      end
      bready = 1;
      @(posedge clk);
      @(negedge clk);
      bready = 0;
      #1 chk("R2 accept after response", {29'd0, bvalid, awready, wready}, 32'd3);
      @(posedge clk);
      @(negedge clk);
      awvalid = 0; wvalid = 0;
      chk("R2 second response", {31'd0, bvalid}, 32'd1);
      bready = 1;
      @(posedge clk);
      @(negedge clk);
      bready = 0;

      finish_run();
   end

endmodule